// File: doc/BRIEF.md
# Debug Register Access Permission Filter

This block guards two small memory-mapped register windows: an external debug window and a performance-monitor window. Each single-beat read or write carries a window select and a byte offset. The filter classifies the offset as reserved, status, scratch or unimplemented. For reserved offsets it applies a fixed chain of checks. The first link covers power and lock state. The second is the external debug enable. The third is the external performance-monitor enable. It returns one registered response per request, carrying an error flag, a 32-bit read word and a two-bit code that names the check which refused the access.

A reserved offset that passes every check reads as zero and ignores writes. A refused one is answered in the style picked by the `ERR_NOT_RES0` parameter. Four scratch words per window store data. A sticky status word in the debug window gathers one-cycle event pulses and is cleared by reading it, unless the double-lock is active.

Top module: `dbg_access_filter`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_err`, `rsp_cause` and `rsp_rdata` are zero, and every scratch word and the status word read back as zero.
- R2: A response appears in the cycle after each cycle with `req_sel` high, and `rsp_valid` is low in every other cycle.
- R3: A reserved offset is refused with cause 1 when `pwr_on` is low, `dlock` is high or `oslock` is high, whatever the enables are. Reserved offsets are 0x000..0xCFF in the debug window (`req_pmu`=0), and 0x000..0x0FF and 0x400..0x47F in the performance-monitor window (`req_pmu`=1).
- R4: When no cause-1 condition holds, debug offsets 0x400..0x4FF and 0x800..0x8FF are refused with cause 2 while `ext_dbg_en` is low.
- R5: When no cause-1 condition holds, reserved performance-monitor offsets are refused with cause 3 while `ext_pmu_en` is low. `ext_dbg_en` has no effect on that window.
- R6: On a refused access, `rsp_rdata` is zero and `rsp_err` equals `ERR_NOT_RES0`, so it is 1 by default and 0 in read-as-zero mode.
- R7: A reserved offset that passes every check, and any unimplemented offset, returns cause 0, error 0 and data 0. Examples are debug 0x000..0x3FF with `ext_dbg_en` low, and performance-monitor 0x480 with `ext_pmu_en` low.
- R8: Scratch words sit at debug offsets 0xD04+4i and performance-monitor offsets 0x800+4i, for i below `N_SCR`. Writes to them are stored and read back independently of any fault input. Write responses carry zero data.
- R9: The status word is at debug offset 0xD00. Each `evt[i]` pulse sets bit i. A read returns the bits in the low `STAT_W` bits with zeros above, then clears them when `dlock` is low. Writes to it are ignored.
- R10: A status read while `dlock` is high leaves every status bit set.
- R11: An event pulse in the same cycle as a clearing status read is held. The read returns the old value, and the next read shows the event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_sel | input | 1 | Request strobe, one access per cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_pmu | input | 1 | Window: 0 = debug, 1 = performance monitor |
| req_addr | input | 12 | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| pwr_on | input | 1 | Core power domain is up |
| dlock | input | 1 | Double-lock active |
| oslock | input | 1 | OS lock set |
| ext_dbg_en | input | 1 | External debug access allowed |
| ext_pmu_en | input | 1 | External performance-monitor access allowed |
| evt | input | 8 | Single-cycle status event pulses |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Error response |
| rsp_cause | output | 2 | 0 none, 1 power/lock, 2 debug disabled, 3 monitor disabled |
| rsp_rdata | output | 32 | Read data |

## Verification
A wrong step in the priority chain shows on `rsp_cause` in the very next cycle after the faulty request. Random stimulus raises several fault inputs together, so an out-of-order check shows up early. A corrupted scratch or status word stays hidden until that offset is read. The status word, however, is read often enough for a lost event or a wrongful clear to show within a few accesses.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_LOCK = 2'd1,
    CAUSE_DBG  = 2'd2,
    CAUSE_PMU  = 2'd3
  } cause_e;

  localparam int unsigned OFS_W = 12;
  localparam int unsigned WRD_W = OFS_W - 2;

  localparam logic [OFS_W-1:0] DBG_RSV_LAST = 12'hCFF;
  localparam logic [WRD_W-1:0] STAT_WORD    = 10'h340;
  localparam logic [WRD_W-1:0] DSCR_WORD    = 10'h341;
  localparam logic [WRD_W-1:0] PSCR_WORD    = 10'h200;

  typedef struct packed {
    logic rsvd;
    logic dbg_gated;
    logic pmu_gated;
    logic stat_hit;
    logic scr_hit;
  } ofs_cls_t;

endpackage

// File: rtl/dbgf_decode.sv
module dbgf_decode
  import dbgf_pkg::*;
#(
  parameter int unsigned N_SCR = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             pmu_win,
  input  logic [OFS_W-1:0] addr,
  output ofs_cls_t         cls,
  output logic [IDX_W-1:0] scr_idx
);

  logic [WRD_W-1:0] word;
  logic [WRD_W-1:0] dofs;
  logic [WRD_W-1:0] pofs;

  assign word = addr[OFS_W-1:2];
  assign dofs = word - DSCR_WORD;
  assign pofs = word - PSCR_WORD;

  always_comb begin
    cls     = '0;
    scr_idx = '0;
    if (!pmu_win) begin
      cls.rsvd      = (addr <= DBG_RSV_LAST);
      cls.dbg_gated = (addr[11:8] == 4'h4) || (addr[11:8] == 4'h8);
      cls.stat_hit  = (word == STAT_WORD);
      cls.scr_hit   = (dofs < WRD_W'(N_SCR));
      scr_idx       = dofs[IDX_W-1:0];
    end else begin
      cls.rsvd      = (addr[11:8] == 4'h0) || (addr[11:7] == 5'b01000);
      cls.pmu_gated = cls.rsvd;
      cls.scr_hit   = (pofs < WRD_W'(N_SCR));
      scr_idx       = pofs[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/dbgf_prio.sv
module dbgf_prio
  import dbgf_pkg::*;
(
  input  ofs_cls_t cls,
  input  logic     pwr_on,
  input  logic     dlock,
  input  logic     oslock,
  input  logic     dbg_en,
  input  logic     pmu_en,
  output cause_e   cause
);

  logic lock_flt;
  assign lock_flt = !pwr_on || dlock || oslock;

  always_comb begin
    if (!cls.rsvd)                    cause = CAUSE_NONE;
    else if (lock_flt)                cause = CAUSE_LOCK;
    else if (cls.dbg_gated && !dbg_en) cause = CAUSE_DBG;
    else if (cls.pmu_gated && !pmu_en) cause = CAUSE_PMU;
    else                              cause = CAUSE_NONE;
  end

endmodule

// File: rtl/dbgf_regs.sv
module dbgf_regs #(
  parameter int unsigned N_SCR  = 4,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned DW     = 32,
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scr_wr,
  input  logic              pmu_win,
  input  logic [IDX_W-1:0]  scr_idx,
  input  logic [DW-1:0]     wdata,
  input  logic              stat_rd,
  input  logic              dlock,
  input  logic [STAT_W-1:0] evt,
  output logic [DW-1:0]     scr_rdata,
  output logic [STAT_W-1:0] stat_q
);

  logic [DW-1:0] scr_q [2][N_SCR];

  for (genvar w = 0; w < 2; w++) begin : g_bank
    for (genvar i = 0; i < N_SCR; i++) begin : g_word
      logic we;
      assign we = scr_wr && (pmu_win == w[0]) && (scr_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  scr_q[w][i] <= '0;
        else if (we) scr_q[w][i] <= wdata;
      end
    end
  end

  assign scr_rdata = scr_q[pmu_win][scr_idx];

  logic              stat_clr;
  logic [STAT_W-1:0] stat_d;

  assign stat_clr = stat_rd && !dlock;

  always_comb begin
    if (stat_clr) stat_d = evt;
    else          stat_d = stat_q | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  // R10
  dlock_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && dlock) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R11
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/dbg_access_filter.sv
module dbg_access_filter
  import dbgf_pkg::*;
#(
  parameter int unsigned N_SCR        = 4,
  parameter int unsigned DW           = 32,
  parameter int unsigned STAT_W       = 8,
  parameter bit          ERR_NOT_RES0 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_sel,
  input  logic              req_wr,
  input  logic              req_pmu,
  input  logic [11:0]       req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              pwr_on,
  input  logic              dlock,
  input  logic              oslock,
  input  logic              ext_dbg_en,
  input  logic              ext_pmu_en,
  input  logic [STAT_W-1:0] evt,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [1:0]        rsp_cause,
  output logic [DW-1:0]     rsp_rdata
);

  localparam int unsigned IDX_W = (N_SCR > 1) ? $clog2(N_SCR) : 1;

  ofs_cls_t          cls;
  logic [IDX_W-1:0]  scr_idx;
  cause_e            cause;
  logic              refused;
  logic              scr_wr;
  logic              stat_rd;
  logic [DW-1:0]     scr_rdata;
  logic [STAT_W-1:0] stat_q;
  logic [DW-1:0]     rd_word;

  dbgf_decode #(.N_SCR(N_SCR), .IDX_W(IDX_W)) u_decode (
    .pmu_win (req_pmu),
    .addr    (req_addr),
    .cls     (cls),
    .scr_idx (scr_idx)
  );

  dbgf_prio u_prio (
    .cls    (cls),
    .pwr_on (pwr_on),
    .dlock  (dlock),
    .oslock (oslock),
    .dbg_en (ext_dbg_en),
    .pmu_en (ext_pmu_en),
    .cause  (cause)
  );

  assign refused = (cause != CAUSE_NONE);
  assign scr_wr  = req_sel && req_wr && cls.scr_hit;
  assign stat_rd = req_sel && !req_wr && cls.stat_hit;

  dbgf_regs #(.N_SCR(N_SCR), .IDX_W(IDX_W), .DW(DW), .STAT_W(STAT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .scr_wr    (scr_wr),
    .pmu_win   (req_pmu),
    .scr_idx   (scr_idx),
    .wdata     (req_wdata),
    .stat_rd   (stat_rd),
    .dlock     (dlock),
    .evt       (evt),
    .scr_rdata (scr_rdata),
    .stat_q    (stat_q)
  );

  always_comb begin
    rd_word = '0;
    if (!req_wr && !refused) begin
      if (cls.stat_hit)     rd_word = {{(DW-STAT_W){1'b0}}, stat_q};
      else if (cls.scr_hit) rd_word = scr_rdata;
    end
  end

  logic          vld_d, err_d;
  logic [1:0]    cause_d;
  logic [DW-1:0] rdata_d;

  always_comb begin
    vld_d   = req_sel;
    err_d   = req_sel && refused && ERR_NOT_RES0;
    cause_d = req_sel ? cause : CAUSE_NONE;
    rdata_d = req_sel ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_cause <= 2'd0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= vld_d;
      rsp_err   <= err_d;
      rsp_cause <= cause_d;
      rsp_rdata <= rdata_d;
    end
  end

  // R2
  rsp_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_sel |=> rsp_valid);

  // R2
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_sel |=> !rsp_valid);

  // R6
  reject_style_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != 2'd0) |-> (rsp_rdata == '0 && rsp_err == ERR_NOT_RES0));

  // R3
  lock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sel && cls.rsvd && (!pwr_on || dlock || oslock)) |=> (rsp_cause == 2'd1));

endmodule

// File: tb/test_dbg_access_filter.sv
`timescale 1ns/1ps
module test_dbg_access_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_sel = 0, req_wr = 0, req_pmu = 0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        pwr_on = 1, dlock = 0, oslock = 0, ext_dbg_en = 1, ext_pmu_en = 1;
  logic [7:0]  evt = '0;

  logic        a_vld, a_err, z_vld, z_err;
  logic [1:0]  a_cause, z_cause;
  logic [31:0] a_data, z_data;

  int tests = 0;
  int fails = 0;

  logic [31:0] m_scr [2][4];
  logic [7:0]  m_stat = '0;

  always #4 clk = ~clk;

  dbg_access_filter i_dbg_access_filter (
    .clk(clk), .rst_n(rst_n), .req_sel(req_sel), .req_wr(req_wr), .req_pmu(req_pmu),
    .req_addr(req_addr), .req_wdata(req_wdata), .pwr_on(pwr_on), .dlock(dlock),
    .oslock(oslock), .ext_dbg_en(ext_dbg_en), .ext_pmu_en(ext_pmu_en), .evt(evt),
    .rsp_valid(a_vld), .rsp_err(a_err), .rsp_cause(a_cause), .rsp_rdata(a_data));

  dbg_access_filter #(.ERR_NOT_RES0(1'b0)) i_dbg_access_filter_z (
    .clk(clk), .rst_n(rst_n), .req_sel(req_sel), .req_wr(req_wr), .req_pmu(req_pmu),
    .req_addr(req_addr), .req_wdata(req_wdata), .pwr_on(pwr_on), .dlock(dlock),
    .oslock(oslock), .ext_dbg_en(ext_dbg_en), .ext_pmu_en(ext_pmu_en), .evt(evt),
    .rsp_valid(z_vld), .rsp_err(z_err), .rsp_cause(z_cause), .rsp_rdata(z_data));

  function automatic logic [1:0] f_cause(bit pmu, logic [11:0] a, bit pw, bit dl,
                                         bit ol, bit de, bit pe);
    int w = int'(a);
    bit res, gd, gp;
    if (!pmu) begin
      res = w < 'hD00;
      gd  = (w >= 'h400 && w < 'h500) || (w >= 'h800 && w < 'h900);
      gp  = 0;
    end else begin
      res = (w < 'h100) || (w >= 'h400 && w < 'h480);
      gd  = 0;
      gp  = res;
    end
    if (!res) return 2'd0;
    if (!pw || dl || ol) return 2'd1;
    if (gd && !de) return 2'd2;
    if (gp && !pe) return 2'd3;
    return 2'd0;
  endfunction

  function automatic int f_scr(bit pmu, logic [11:0] a);
    int w = int'(a[11:2]);
    int b = pmu ? ('h800 >> 2) : ('hD04 >> 2);
    if (w >= b && w < b + 4) return w - b;
    return -1;
  endfunction

  function automatic bit f_stat(bit pmu, logic [11:0] a);
    return !pmu && (a[11:2] == 10'h340);
  endfunction

  task automatic chk(string tag, bit ok, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic acc(string tag, bit sel, bit wr, bit pmu, logic [11:0] a,
                     logic [31:0] wd, logic [7:0] ev);
    logic [1:0]  ec;
    logic [31:0] ed;
    int          si;
    string       t;
    req_sel = sel; req_wr = wr; req_pmu = pmu; req_addr = a; req_wdata = wd; evt = ev;
    ec = sel ? f_cause(pmu, a, pwr_on, dlock, oslock, ext_dbg_en, ext_pmu_en) : 2'd0;
    si = f_scr(pmu, a);
    ed = '0;
    if (sel && !wr && ec == 0) begin
      if (f_stat(pmu, a)) ed = {24'd0, m_stat};
      else if (si >= 0)   ed = m_scr[pmu][si];
    end
    t = tag;
    if (t == "") begin
      if (!sel)               t = "R2";
      else if (ec == 1)       t = "R3";
      else if (ec == 2)       t = "R4";
      else if (ec == 3)       t = "R5";
      else if (f_stat(pmu, a)) t = "R9";
      else if (si >= 0)       t = "R8";
      else                    t = "R7";
    end
    if (sel && wr && si >= 0) m_scr[pmu][si] = wd;
    if (sel && !wr && f_stat(pmu, a) && !dlock) m_stat = ev;
    else m_stat = m_stat | ev;
    @(posedge clk);
    @(negedge clk);
    chk(t, a_vld == sel && z_vld == sel, "valid", {a_vld, z_vld}, {sel, sel});
    if (sel) begin
      chk(t, a_cause == ec && z_cause == ec, "cause", {a_cause, z_cause}, {ec, ec});
      chk(t, a_data == ed && z_data == ed, "data", {a_data, z_data}, {ed, ed});
      chk(ec != 0 ? "R6" : t, a_err == (ec != 0) && z_err == 1'b0, "err",
          {a_err, z_err}, {(ec != 0), 1'b0});
    end
    req_sel = 0; evt = '0;
  endtask

  task automatic faults(bit pw, bit dl, bit ol, bit de, bit pe);
    pwr_on = pw; dlock = dl; oslock = ol; ext_dbg_en = de; ext_pmu_en = pe;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1F2E3D4C);
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 4; i++) m_scr[w][i] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs at reset
    chk("R1", a_vld == 0 && a_err == 0 && a_cause == 0 && a_data == 0, "reset outs",
        {a_vld, a_err, a_cause, a_data}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    acc("R1", 1, 0, 0, 12'hD00, 0, 0);
    acc("R1", 1, 0, 1, 12'h80C, 0, 0);
    acc("R2", 0, 0, 0, 12'h000, 0, 0);

    // R3: lock class, including with other faults set
    faults(1, 0, 1, 0, 0); acc("R3", 1, 0, 0, 12'h400, 0, 0);
    faults(0, 0, 0, 0, 0); acc("R3", 1, 0, 1, 12'h000, 0, 0);
    faults(1, 1, 0, 1, 0); acc("R3", 1, 1, 1, 12'h440, 32'hFFFF, 0);
    faults(1, 0, 1, 1, 1); acc("R3", 1, 0, 0, 12'hCFC, 0, 0);
    // R4 over R5 and plain enables
    faults(1, 0, 0, 0, 0); acc("R4", 1, 0, 0, 12'h8FC, 0, 0);
    acc("R5", 1, 0, 1, 12'h0FC, 0, 0);
    acc("R5", 1, 0, 1, 12'h47C, 0, 0);
    // R7: passing reserved and unimplemented
    acc("R7", 1, 0, 0, 12'h100, 0, 0);
    acc("R7", 1, 0, 0, 12'h500, 0, 0);
    acc("R7", 1, 0, 1, 12'h480, 0, 0);
    acc("R7", 1, 0, 0, 12'hFFC, 0, 0);
    // R8: scratch under faults
    faults(0, 1, 1, 0, 0);
    acc("R8", 1, 1, 0, 12'hD10, 32'hCAFE0001, 0);
    acc("R8", 1, 1, 1, 12'h800, 32'hBEEF0002, 0);
    acc("R8", 1, 0, 0, 12'hD10, 0, 0);
    acc("R8", 1, 0, 1, 12'h800, 0, 0);
    // R9 / R10 / R11: status
    faults(1, 0, 0, 1, 1);
    acc("R9", 0, 0, 0, 0, 0, 8'h05);
    acc("R9", 1, 1, 0, 12'hD00, 32'hFFFFFFFF, 0);
    faults(1, 1, 0, 1, 1);
    acc("R10", 1, 0, 0, 12'hD00, 0, 0);
    acc("R10", 1, 0, 0, 12'hD00, 0, 0);
    faults(1, 0, 0, 1, 1);
    acc("R11", 1, 0, 0, 12'hD00, 0, 8'h80);
    acc("R11", 1, 0, 0, 12'hD00, 0, 0);
    acc("R9", 1, 0, 0, 12'hD00, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      bit          pmu;
      logic [11:0] a;
      int          k;
      faults(($urandom % 4) != 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
             ($urandom % 2) == 0, ($urandom % 2) == 0);
      pmu = $urandom % 2;
      k   = $urandom % 8;
      if (k == 0)      a = pmu ? 12'h800 + 12'(4 * ($urandom % 4)) : 12'hD00;
      else if (k == 1) a = pmu ? 12'h400 + 12'(($urandom % 64) << 2)
                               : 12'hD04 + 12'(4 * ($urandom % 4));
      else             a = 12'($urandom) & 12'hFFC;
      acc("", ($urandom % 8) != 0, ($urandom % 3) == 0, pmu, a, $urandom,
          (($urandom % 6) == 0) ? 8'($urandom) : 8'h00);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule